// File: doc/BRIEF.md
# Streaming Second-Order Image Moment Accumulator

This block watches a raster pixel stream and, over one frame, sums the geometric moments of order zero, one and two for the pixels that qualify. A pixel qualifies either by being nonzero (binary image) or by being equal to a selected label (labelled image). A column counter gives x and a row counter gives y. The power terms x², x·y and y² are kept current by additions alone, with no multipliers: a step of x adds 2x+1 to x² and y to x·y, and a step of y adds 2y+1 to y². Six accumulators add the count, x, y, x², x·y and y² of each qualifying pixel.

At every frame sync the six sums of the frame that just ended are copied into output registers, and a done flag goes high for one cycle. The outputs then hold steady while the next frame builds up. A small control machine has two states. `ST_WAIT` is entered from reset and ignores the stream. The transition *arm* (a frame sync in `ST_WAIT`) moves it to `ST_RUN`. In `ST_RUN` the transition *publish* (a frame sync) latches the results, pulses done and stays in `ST_RUN`.

Top module: `img_moment_acc`

## Requirements
- R1: The column coordinate x starts at 0 and advances by one on each accepted pixel strobe. After IMG_W-1 it wraps to 0. The row coordinate y advances by one on each accepted line sync and wraps to 0 after IMG_H-1.
- R2: The incremental terms always equal x·x, x·y and y·y for the current coordinates, including after wraps and clears.
- R3: Frame sync has priority over line sync, and line sync has priority over the pixel strobe. A pixel strobe in the same cycle as either sync is ignored: it is not summed and x does not advance.
- R4: With label_mode=0 a pixel qualifies when pix_val is nonzero. With label_mode=1 it qualifies when pix_val equals label_sel, and this includes label 0.
- R5: In `ST_RUN` each qualifying accepted pixel adds 1, x, y, x², x·y and y² to the sums reported on mom_00, mom_10, mom_01, mom_20, mom_11 and mom_02.
- R6: A frame sync in `ST_RUN` copies the sums of all pixels accepted before that cycle to the outputs, which are visible after that clock edge. res_done is high for exactly that following cycle. The sums then restart from zero.
- R7: Between publishes the output registers keep their values, whatever pixels arrive.
- R8: In `ST_WAIT` pixels are not summed. The first frame sync (arm) gives no done pulse and leaves the outputs unchanged.
- R9: A line sync clears x. A frame sync clears x and y.
- R10: After reset all outputs are zero, res_done is low and the state is `ST_WAIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_stb | input | 1 | One pixel present this cycle |
| line_sync | input | 1 | End-of-line pulse |
| frame_sync | input | 1 | Frame boundary pulse |
| label_mode | input | 1 | 0: nonzero qualifies, 1: label match qualifies |
| label_sel | input | PIX_W | Label to match in label mode |
| pix_val | input | PIX_W | Pixel value |
| res_done | output | 1 | One-cycle pulse when new results are latched |
| mom_00 | output | ACC_W | Qualifying pixel count |
| mom_10 | output | ACC_W | Sum of x |
| mom_01 | output | ACC_W | Sum of y |
| mom_20 | output | ACC_W | Sum of x² |
| mom_11 | output | ACC_W | Sum of x·y |
| mom_02 | output | ACC_W | Sum of y² |

## Verification
A wrong coordinate or power term stays hidden until the next publish. It then shows as wrong first- or second-order sums, while mom_00 often remains correct. A miscounted x after a wrap changes mom_10 and mom_20 only for pixels later on the same line. A lost priority between the syncs and the strobe shows up as an extra count in mom_00 at the publish. A wrong state before arm shows up at once as a done pulse on the first frame sync. A fault in the output hold is visible on the very next cycle, without waiting for the end of the frame.

// File: rtl/img_mom_pkg.sv
package img_mom_pkg;
    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } mom_state_e;

    localparam int MOM_N   = 6;
    localparam int IDX_M00 = 0;
    localparam int IDX_M10 = 1;
    localparam int IDX_M01 = 2;
    localparam int IDX_M20 = 3;
    localparam int IDX_M11 = 4;
    localparam int IDX_M02 = 5;
endpackage

// File: rtl/img_mom_axis.sv
// Coordinate counter with its square kept up to date by additions only.
module img_mom_axis #(
    parameter int LIMIT = 640,
    localparam int CW   = $clog2(LIMIT),
    localparam int SQ_W = 2 * CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            step,
    output logic [CW-1:0]   coord_o,
    output logic [SQ_W-1:0] sq_o,
    output logic            last_o
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    assign last_o = (coord_o == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coord_o <= '0;
            sq_o    <= '0;
        end else if (clr) begin
            coord_o <= '0;
            sq_o    <= '0;
        end else if (step) begin
            if (last_o) begin
                coord_o <= '0;
                sq_o    <= '0;
            end else begin
                coord_o <= coord_o + 1'b1;
                sq_o    <= sq_o + SQ_W'({coord_o, 1'b1});
            end
        end
    end

    // R1
    coord_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coord_o <= LAST);

    // R1
    coord_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !last_o) |=> coord_o == $past(coord_o) + 1'b1);

    // R2
    sq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_o == SQ_W'(coord_o) * SQ_W'(coord_o));

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (coord_o == '0 && sq_o == '0));
endmodule

// File: rtl/img_mom_cross.sv
// Mixed term x*y: grows by y on each column step, clears with the column.
module img_mom_cross #(
    parameter int XCW  = 10,
    parameter int YCW  = 9,
    localparam int XYW = XCW + YCW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           step,
    input  logic           wrap,
    input  logic [XCW-1:0] x_i,
    input  logic [YCW-1:0] y_i,
    output logic [XYW-1:0] xy_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xy_o <= '0;
        end else if (clr || (step && wrap)) begin
            xy_o <= '0;
        end else if (step) begin
            xy_o <= xy_o + XYW'(y_i);
        end
    end

    // R2
    xy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xy_o == XYW'(x_i) * XYW'(y_i));
endmodule

// File: rtl/img_mom_acc.sv
// One gated moment accumulator.
module img_mom_acc #(
    parameter int ACC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] acc_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else if (clr) begin
            acc_o <= '0;
        end else if (en) begin
            acc_o <= acc_o + addend;
        end
    end

    // R5
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(acc_o));

    // R6
    acc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> acc_o == '0);
endmodule

// File: rtl/img_moment_acc.sv
module img_moment_acc
    import img_mom_pkg::*;
#(
    parameter int IMG_W = 640,
    parameter int IMG_H = 480,
    parameter int PIX_W = 8,
    parameter int ACC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_stb,
    input  logic             line_sync,
    input  logic             frame_sync,
    input  logic             label_mode,
    input  logic [PIX_W-1:0] label_sel,
    input  logic [PIX_W-1:0] pix_val,
    output logic             res_done,
    output logic [ACC_W-1:0] mom_00,
    output logic [ACC_W-1:0] mom_10,
    output logic [ACC_W-1:0] mom_01,
    output logic [ACC_W-1:0] mom_20,
    output logic [ACC_W-1:0] mom_11,
    output logic [ACC_W-1:0] mom_02
);
    localparam int XCW = $clog2(IMG_W);
    localparam int YCW = $clog2(IMG_H);
    localparam int XSQ = 2 * XCW;
    localparam int YSQ = 2 * YCW;
    localparam int XYW = XCW + YCW;

    mom_state_e st_q, st_d;

    logic           ls_acc, px_acc, hit, acc_en, publish, x_last, y_last;
    logic [XCW-1:0] x_q;
    logic [YCW-1:0] y_q;
    logic [XSQ-1:0] x2_q;
    logic [YSQ-1:0] y2_q;
    logic [XYW-1:0] xy_q;
    logic [ACC_W-1:0] addend [MOM_N];
    logic [ACC_W-1:0] acc_q  [MOM_N];
    logic [ACC_W-1:0] res_q  [MOM_N];

    // Priority: frame sync, then line sync, then pixel strobe.
    assign ls_acc  = line_sync & ~frame_sync;
    assign px_acc  = pix_stb & ~line_sync & ~frame_sync;
    assign hit     = label_mode ? (pix_val == label_sel) : (|pix_val);
    assign acc_en  = px_acc & hit & (st_q == ST_RUN);
    assign publish = frame_sync & (st_q == ST_RUN);

    img_mom_axis #(.LIMIT(IMG_W)) u_xaxis (
        .clk(clk), .rst_n(rst_n),
        .clr(frame_sync | line_sync), .step(px_acc),
        .coord_o(x_q), .sq_o(x2_q), .last_o(x_last)
    );

    img_mom_axis #(.LIMIT(IMG_H)) u_yaxis (
        .clk(clk), .rst_n(rst_n),
        .clr(frame_sync), .step(ls_acc),
        .coord_o(y_q), .sq_o(y2_q), .last_o(y_last)
    );

    img_mom_cross #(.XCW(XCW), .YCW(YCW)) u_cross (
        .clk(clk), .rst_n(rst_n),
        .clr(frame_sync | line_sync), .step(px_acc), .wrap(x_last),
        .x_i(x_q), .y_i(y_q), .xy_o(xy_q)
    );

    assign addend[IDX_M00] = ACC_W'(1);
    assign addend[IDX_M10] = ACC_W'(x_q);
    assign addend[IDX_M01] = ACC_W'(y_q);
    assign addend[IDX_M20] = ACC_W'(x2_q);
    assign addend[IDX_M11] = ACC_W'(xy_q);
    assign addend[IDX_M02] = ACC_W'(y2_q);

    for (genvar g = 0; g < MOM_N; g++) begin : g_acc
        img_mom_acc #(.ACC_W(ACC_W)) u_acc (
            .clk(clk), .rst_n(rst_n),
            .clr(frame_sync), .en(acc_en),
            .addend(addend[g]), .acc_o(acc_q[g])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_WAIT;
        else        st_q <= st_d;
    end

    // Next state: arm (WAIT->RUN), publish (RUN->RUN)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WAIT: if (frame_sync) st_d = ST_RUN;
            ST_RUN:  st_d = ST_RUN;
            default: st_d = ST_WAIT;
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_done <= 1'b0;
            for (int i = 0; i < MOM_N; i++) res_q[i] <= '0;
        end else begin
            res_done <= publish;
            if (publish) begin
                for (int i = 0; i < MOM_N; i++) res_q[i] <= acc_q[i];
            end
        end
    end

    assign mom_00 = res_q[IDX_M00];
    assign mom_10 = res_q[IDX_M10];
    assign mom_01 = res_q[IDX_M01];
    assign mom_20 = res_q[IDX_M20];
    assign mom_11 = res_q[IDX_M11];
    assign mom_02 = res_q[IDX_M02];

    // R6
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> $past(frame_sync));

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !publish |=> ($stable(mom_00) && $stable(mom_10) && $stable(mom_01)
                      && $stable(mom_20) && $stable(mom_11) && $stable(mom_02)));

    // R8
    wait_nodone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |=> !res_done);

    // R3
    sync_px_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_stb && line_sync && !frame_sync) |=> x_q == '0);
endmodule

// File: tb/img_moment_acc_bench.sv
`timescale 1ns/1ps
module img_moment_acc_bench;
    localparam int W  = 8;
    localparam int H  = 6;
    localparam int PW = 4;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_stb = 1'b0, line_sync = 1'b0, frame_sync = 1'b0, label_mode = 1'b0;
    logic [PW-1:0] label_sel = '0, pix_val = '0;
    logic res_done;
    logic [AW-1:0] mom_00, mom_10, mom_01, mom_20, mom_11, mom_02;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model state
    int bx = 0, by = 0;
    bit brun = 0;
    longint esum [6];
    logic [AW-1:0] eout [6];

    always #2.5 clk = ~clk;

    img_moment_acc #(.IMG_W(W), .IMG_H(H), .PIX_W(PW), .ACC_W(AW)) u_img_moment_acc (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .line_sync(line_sync),
        .frame_sync(frame_sync), .label_mode(label_mode), .label_sel(label_sel),
        .pix_val(pix_val), .res_done(res_done),
        .mom_00(mom_00), .mom_10(mom_10), .mom_01(mom_01),
        .mom_20(mom_20), .mom_11(mom_11), .mom_02(mom_02)
    );

    function automatic logic [AW-1:0] got(int i);
        case (i)
            0: return mom_00;
            1: return mom_10;
            2: return mom_01;
            3: return mom_20;
            4: return mom_11;
            default: return mom_02;
        endcase
    endfunction

    function automatic logic [PW-1:0] pat_val(int pat, int x, int y);
        case (pat)
            0: return 4'd1;
            1: return ((x + y) % 3 == 0) ? 4'd1 : 4'd0;
            2: return 4'((x * 3 + y * 5) % 7);
            default: return 4'd0;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [AW-1:0] a, logic [AW-1:0] e);
        total++;
        if (a !== e) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, a, e);
        end
    endtask

    // One cycle of stimulus; model follows the requirements.
    task automatic cyc(bit stb, bit ls, bit fs, logic [PW-1:0] v);
        bit q;
        pix_stb = stb; line_sync = ls; frame_sync = fs; pix_val = v;
        q = label_mode ? (v == label_sel) : (v != 0);
        if (fs) begin
            if (brun) for (int i = 0; i < 6; i++) eout[i] = AW'(esum[i]);
            brun = 1;
            for (int i = 0; i < 6; i++) esum[i] = 0;
            bx = 0; by = 0;
        end else if (ls) begin
            bx = 0;
            by = (by == H - 1) ? 0 : by + 1;
        end else if (stb) begin
            if (brun && q) begin
                esum[0] += 1;        esum[1] += bx;      esum[2] += by;
                esum[3] += bx * bx;  esum[4] += bx * by; esum[5] += by * by;
            end
            bx = (bx == W - 1) ? 0 : bx + 1;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(0, 0, 0, '0);
    endtask

    task automatic chk_outs(string req, string what);
        for (int i = 0; i < 6; i++)
            chk(req, $sformatf("%s mom[%0d]", what, i), got(i), eout[i]);
    endtask

    task automatic end_frame(string what, bit stb);
        cyc(stb, 0, 1, 4'd1);
        chk("R6", {what, " done high"}, AW'(res_done), 1);
        chk_outs("R5", what);
        idle();
        chk("R6", {what, " done one cycle"}, AW'(res_done), 0);
        chk_outs("R7", {what, " hold"});
    endtask

    task automatic run_frame(int pat, bit gap);
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                cyc(1, 0, 0, pat_val(pat, x, y));
                if (gap && (x % 2 == 1)) idle();
            end
            cyc(0, 1, 0, '0);
        end
    endtask

    task automatic t_reset();
        chk("R10", "done after reset", AW'(res_done), 0);
        for (int i = 0; i < 6; i++) eout[i] = '0;
        chk_outs("R10", "reset");
    endtask

    task automatic t_prearm();
        for (int k = 0; k < 5; k++) cyc(1, 0, 0, 4'd1);
        cyc(0, 1, 0, '0);
        cyc(1, 0, 0, 4'd1);
        cyc(0, 0, 1, '0);
        chk("R8", "no done on arm", AW'(res_done), 0);
        chk_outs("R8", "arm leaves outputs");
    endtask

    task automatic t_full();
        label_mode = 0;
        run_frame(0, 0);
        end_frame("full binary", 0);
        chk("R5", "full count", mom_00, AW'(W * H));
    endtask

    task automatic t_sparse();
        label_mode = 0;
        run_frame(1, 1);
        end_frame("sparse gaps", 0);
    endtask

    task automatic t_label();
        label_mode = 1; label_sel = 4'd3;
        run_frame(2, 0);
        end_frame("R4 label 3", 0);
        label_sel = 4'd0;
        run_frame(2, 0);
        end_frame("R4 label 0", 0);
        label_mode = 0;
        run_frame(2, 0);
        end_frame("R4 nonzero", 0);
    endtask

    task automatic t_wrap();
        label_mode = 0;
        // R1 x wraps within an overlong line
        for (int k = 0; k < W + 3; k++) cyc(1, 0, 0, 4'd1);
        // R3 strobe with line sync is ignored
        cyc(1, 1, 0, 4'd1);
        cyc(1, 0, 0, 4'd2);
        cyc(1, 0, 0, 4'd5);
        // R1 y wraps after H-1 lines
        for (int k = 0; k < H + 1; k++) begin
            cyc(0, 1, 0, '0);
            cyc(1, 0, 0, 4'd1);
        end
        // R3 strobe with frame sync is ignored
        end_frame("R1 R3 wrap", 1);
    endtask

    task automatic t_hold();
        label_mode = 0;
        for (int k = 0; k < 4; k++) cyc(1, 0, 0, 4'd7);
        chk("R7", "no done mid frame", AW'(res_done), 0);
        chk_outs("R7", "mid frame hold");
        // R9 line sync clears x, then pixel lands at x=0
        cyc(0, 1, 0, '0);
        cyc(1, 0, 0, 4'd1);
        end_frame("R9 after clear", 0);
        chk("R9", "x cleared m10", mom_10, AW'(0 + 1 + 2 + 3));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prearm();
        t_full();
        t_sparse();
        t_label();
        t_wrap();
        t_hold();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule